// File: doc/BRIEF.md
# Coherent Store Buffer with Load Forwarding and Store Fence

This block sits between a core's store port and its private cache. A store is taken into a small circular queue in the cycle it is presented, so the core keeps running. At the same time the block sends out an invalidate request that names the queue slot the store now holds. Peer caches answer with acknowledgements that carry that slot number. Each entry counts the acknowledgements it receives. Only the oldest entry may write the cache, and only once every peer has answered for it.

Loads from the core search the queue. When one or more buffered stores target the load address, the response carries the data of the youngest such store. Otherwise the response reports a miss, and the core reads the cache itself. A fence command makes every store presented after it wait until all stores that were already buffered have been written to the cache.

Top module: `stq_fwd_buf`

## Requirements
- R1: A store presented while `st_stall` is low is accepted in that cycle. In the same cycle `inv_req_valid` is high, with `inv_req_addr` equal to the store address and `inv_req_slot` equal to the allocation slot. Slots are handed out in order 0, 1, 2, ... after reset and wrap modulo DEPTH.
- R2: While the queue holds DEPTH entries, `st_stall` is high whatever `st_valid` is, and no store is accepted.
- R3: Each acknowledgement lane p with `ack_vld[p]` high adds one to the count of the entry in slot `ack_slot[p*IW +: IW]`. The count saturates at PEERS. The head entry drives `cwr_valid`, `cwr_addr` and `cwr_data` in the cycle after the edge that recorded its last acknowledgement, and it leaves the queue at the next edge.
- R4: Entries write the cache strictly in acceptance order. A younger entry that is fully acknowledged waits until every older entry has written.
- R5: A load presented in cycle t gets `ld_rsp_valid` high in cycle t+1. It compares against the entries held at the start of cycle t, which includes one writing the cache in cycle t and excludes a store accepted in cycle t. On a match, `ld_rsp_hit` is 1 and `ld_rsp_data` is the data of the youngest matching entry. On no match, `ld_rsp_hit` is 0 and `ld_rsp_data` is 0.
- R6: A `fence_req` pulse with a non-empty queue after that edge starts a drain phase. A store accepted in the same cycle as the fence counts as older than the fence. During the drain phase, `st_stall` is high in every cycle where `st_valid` is high. The phase ends at the edge where the queue becomes empty.
- R7: A fence issued while the queue is empty, and with no store in the same cycle, starts no drain phase, so a store in the next cycle is accepted.
- R8: An acknowledgement naming a slot that holds no entry has no effect. A store later placed in that slot still needs PEERS fresh acknowledgements before it writes.
- R9: During reset the queue is empty, and `st_stall`, `cwr_valid`, `inv_req_valid` and `ld_rsp_valid` are low.
- R10: Several acknowledgement lanes naming the same slot in one cycle each add one to that entry's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request from the core |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_stall | output | 1 | Store not accepted this cycle |
| fence_req | input | 1 | Store fence command, one-cycle pulse |
| inv_req_valid | output | 1 | Invalidate request for the accepted store |
| inv_req_addr | output | AW | Address to invalidate |
| inv_req_slot | output | IW | Slot tag that acknowledgements must carry |
| ack_vld | input | PEERS | One acknowledgement lane per peer |
| ack_slot | input | PEERS*IW | Slot tag for each lane, lane p at bits p*IW +: IW |
| cwr_valid | output | 1 | Cache write of the head entry |
| cwr_addr | output | AW | Cache write address |
| cwr_data | output | DW | Cache write data |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | AW | Load address |
| ld_rsp_valid | output | 1 | Load response, one cycle after the request |
| ld_rsp_hit | output | 1 | Buffered store found |
| ld_rsp_data | output | DW | Forwarded data, zero on a miss |

## Verification
Two pairs of events can land in one cycle. The first is a load that looks up an entry in the same cycle as that entry writes the cache. The bench provokes this by issuing the load while `cwr_valid` is high, and it expects a hit, because lookup sees the queue as it stood at the start of the cycle. The second is a fence that arrives together with a store. The bench expects that store to be accepted and to be included in the drain, and it expects the store held on `st_valid` during the drain to stay stalled until the queue is empty. A behavioural queue model predicts the expected ports in each of these cycles, and the bench compares against it on every clock.

// File: rtl/stq_pkg.sv
package stq_pkg;
  typedef enum logic {
    FENCE_IDLE  = 1'b0,
    FENCE_DRAIN = 1'b1
  } fence_st_e;
endpackage

// File: rtl/stq_fence_ctl.sv
module stq_fence_ctl
  import stq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fence_req,
  input  logic st_valid,
  input  logic full,
  input  logic empty_next,
  output logic st_stall,
  output logic drain_active
);
  fence_st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if ((state_q == FENCE_DRAIN) || fence_req) begin
      state_d = empty_next ? FENCE_IDLE : FENCE_DRAIN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FENCE_IDLE;
    else        state_q <= state_d;
  end

  assign drain_active = (state_q == FENCE_DRAIN);
  assign st_stall     = full | (drain_active & st_valid);
endmodule

// File: rtl/stq_ack_track.sv
module stq_ack_track #(
  parameter int DEPTH = 4,
  parameter int PEERS = 3,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(PEERS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_en,
  input  logic [IW-1:0]         alloc_slot,
  input  logic [DEPTH-1:0]      live_mask,
  input  logic [PEERS-1:0]      ack_vld,
  input  logic [PEERS*IW-1:0]   ack_slot,
  output logic [DEPTH-1:0]      done_mask
);
  localparam logic [CW:0] PEER_MAX = (CW+1)'(PEERS);

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] hits;
    logic [CW:0]   sum;
    logic          cnt_en;

    always_comb begin
      hits = '0;
      for (int p = 0; p < PEERS; p++) begin
        if (ack_vld[p] && (ack_slot[p*IW +: IW] == IW'(e))) hits = hits + CW'(1);
      end
      sum    = {1'b0, cnt_q} + {1'b0, hits};
      cnt_en = 1'b0;
      cnt_d  = cnt_q;
      if (alloc_en && (alloc_slot == IW'(e))) begin
        cnt_en = 1'b1;
        cnt_d  = '0;
      end else if (live_mask[e] && (hits != '0)) begin
        cnt_en = 1'b1;
        cnt_d  = (sum >= PEER_MAX) ? PEER_MAX[CW-1:0] : sum[CW-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign done_mask[e] = live_mask[e] & ({1'b0, cnt_q} == PEER_MAX);
  end
endmodule

// File: rtl/stq_fwd_sel.sv
module stq_fwd_sel #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic [IW-1:0]              head,
  input  logic [IW:0]                count,
  input  logic [DEPTH-1:0][AW-1:0]   ent_addr,
  input  logic [DEPTH-1:0][DW-1:0]   ent_data,
  input  logic [AW-1:0]              ld_addr,
  output logic                       hit,
  output logic [DW-1:0]              data
);
  logic [IW-1:0] slot;

  // Walk from oldest to youngest; a later match overrides an earlier one.
  always_comb begin
    hit  = 1'b0;
    data = '0;
    slot = head;
    for (int k = 0; k < DEPTH; k++) begin
      slot = head + IW'(k);
      if (((IW+1)'(k) < count) && (ent_addr[slot] == ld_addr)) begin
        hit  = 1'b1;
        data = ent_data[slot];
      end
    end
  end
endmodule

// File: rtl/stq_fwd_buf.sv
module stq_fwd_buf #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int PEERS = 3,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                st_valid,
  input  logic [AW-1:0]       st_addr,
  input  logic [DW-1:0]       st_data,
  output logic                st_stall,
  input  logic                fence_req,
  output logic                inv_req_valid,
  output logic [AW-1:0]       inv_req_addr,
  output logic [IW-1:0]       inv_req_slot,
  input  logic [PEERS-1:0]    ack_vld,
  input  logic [PEERS*IW-1:0] ack_slot,
  output logic                cwr_valid,
  output logic [AW-1:0]       cwr_addr,
  output logic [DW-1:0]       cwr_data,
  input  logic                ld_valid,
  input  logic [AW-1:0]       ld_addr,
  output logic                ld_rsp_valid,
  output logic                ld_rsp_hit,
  output logic [DW-1:0]       ld_rsp_data
);
  localparam logic [IW:0] FULL_CNT = (IW+1)'(DEPTH);

  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;
  logic [IW-1:0]            head_q, head_d, tail_q, tail_d;
  logic [IW:0]              cnt_q, cnt_d;
  logic                     push, pop, full, empty_next, drain_active;
  logic [DEPTH-1:0]         live_mask, done_mask;
  logic                     fwd_hit;
  logic [DW-1:0]            fwd_data;
  logic                     rsp_v_q, rsp_hit_q, rsp_hit_d;
  logic [DW-1:0]            rsp_data_q, rsp_data_d;

  // Occupancy of each slot relative to the head pointer.
  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      live_mask[e] = {1'b0, IW'(IW'(e) - head_q)} < cnt_q;
    end
  end

  assign full = (cnt_q == FULL_CNT);
  assign push = st_valid & ~st_stall;
  assign pop  = (cnt_q != '0) & done_mask[head_q];

  always_comb begin
    head_d     = pop  ? head_q + IW'(1) : head_q;
    tail_d     = push ? tail_q + IW'(1) : tail_q;
    cnt_d      = cnt_q + (IW+1)'(push) - (IW+1)'(pop);
    empty_next = (cnt_d == '0);
  end

  always_comb begin
    rsp_hit_d  = 1'b0;
    rsp_data_d = '0;
    if (ld_valid) begin
      rsp_hit_d  = fwd_hit;
      rsp_data_d = fwd_data;
    end
  end

  stq_fence_ctl u_fence (
    .clk          (clk),
    .rst_n        (rst_n),
    .fence_req    (fence_req),
    .st_valid     (st_valid),
    .full         (full),
    .empty_next   (empty_next),
    .st_stall     (st_stall),
    .drain_active (drain_active)
  );

  stq_ack_track #(.DEPTH(DEPTH), .PEERS(PEERS)) u_acks (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (push),
    .alloc_slot (tail_q),
    .live_mask  (live_mask),
    .ack_vld    (ack_vld),
    .ack_slot   (ack_slot),
    .done_mask  (done_mask)
  );

  stq_fwd_sel #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
    .head     (head_q),
    .count    (cnt_q),
    .ent_addr (addr_q),
    .ent_data (data_q),
    .ld_addr  (ld_addr),
    .hit      (fwd_hit),
    .data     (fwd_data)
  );

  // Entry payload: written only on allocation, no reset needed.
  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail_q] <= st_addr;
      data_q[tail_q] <= st_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop)          head_q <= head_d;
      if (push)         tail_q <= tail_d;
      if (push || pop)  cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q    <= 1'b0;
      rsp_hit_q  <= 1'b0;
      rsp_data_q <= '0;
    end else begin
      rsp_v_q    <= ld_valid;
      rsp_hit_q  <= rsp_hit_d;
      rsp_data_q <= rsp_data_d;
    end
  end

  assign inv_req_valid = push;
  assign inv_req_addr  = st_addr;
  assign inv_req_slot  = tail_q;
  assign cwr_valid     = pop;
  assign cwr_addr      = addr_q[head_q];
  assign cwr_data      = data_q[head_q];
  assign ld_rsp_valid  = rsp_v_q;
  assign ld_rsp_hit    = rsp_hit_q;
  assign ld_rsp_data   = rsp_data_q;
endmodule

// File: rtl/stq_fwd_buf_chk.sv
module stq_fwd_buf_chk #(
  parameter int DEPTH = 4,
  parameter int DW    = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_valid,
  input logic          st_stall,
  input logic          inv_req_valid,
  input logic          cwr_valid,
  input logic          ld_valid,
  input logic          ld_rsp_valid,
  input logic          ld_rsp_hit,
  input logic [DW-1:0] ld_rsp_data,
  input logic [IW:0]   cnt_q,
  input logic          drain_active
);
  a_r1_accept_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_stall && !cwr_valid) |=> (cnt_q == $past(cnt_q) + 1'b1));

  a_r2_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == (IW+1)'(DEPTH)) |-> st_stall);

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (IW+1)'(DEPTH));

  a_r3_retire_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    cwr_valid |-> (cnt_q != '0));

  a_r3_retire_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (cwr_valid && !inv_req_valid) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r5_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> ld_rsp_valid);

  a_r5_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> !ld_rsp_valid);

  a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rsp_valid && !ld_rsp_hit) |-> (ld_rsp_data == '0));

  a_r6_drain_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_active && st_valid) |-> st_stall);

  a_r6_drain_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    drain_active |-> (cnt_q != '0));
endmodule

bind stq_fwd_buf stq_fwd_buf_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .st_valid      (st_valid),
  .st_stall      (st_stall),
  .inv_req_valid (inv_req_valid),
  .cwr_valid     (cwr_valid),
  .ld_valid      (ld_valid),
  .ld_rsp_valid  (ld_rsp_valid),
  .ld_rsp_hit    (ld_rsp_hit),
  .ld_rsp_data   (ld_rsp_data),
  .cnt_q         (cnt_q),
  .drain_active  (drain_active)
);

// File: tb/stq_fwd_buf_bench.sv
`timescale 1ns/1ps
module stq_fwd_buf_bench;
  localparam int DEPTH = 4, AW = 16, DW = 32, PEERS = 3, IW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic st_valid, fence_req, ld_valid;
  logic [AW-1:0] st_addr, ld_addr;
  logic [DW-1:0] st_data;
  logic [PEERS-1:0] ack_vld;
  logic [PEERS*IW-1:0] ack_slot;
  logic st_stall, inv_req_valid, cwr_valid, ld_rsp_valid, ld_rsp_hit;
  logic [AW-1:0] inv_req_addr, cwr_addr;
  logic [IW-1:0] inv_req_slot;
  logic [DW-1:0] cwr_data, ld_rsp_data;

  always #2.5 clk = ~clk;

  stq_fwd_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PEERS(PEERS)) u_stq_fwd_buf (.*);

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; int acks; int slot; } ent_t;
  ent_t q[$];
  int   m_tail;
  bit   m_drain, e_rv, e_hit, done;
  logic [DW-1:0] e_rd;
  string cur_req = "R9";
  int n_chk = 0, n_fail = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on each edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_tail = 0; m_drain = 0; e_rv = 0; e_hit = 0; e_rd = '0;
    end else begin
      bit stall, pop;
      e_rv = ld_valid; e_hit = 0; e_rd = '0;
      if (ld_valid) foreach (q[i]) if (q[i].a == ld_addr) begin e_hit = 1; e_rd = q[i].d; end
      pop   = (q.size() > 0) && (q[0].acks == PEERS);
      stall = (q.size() == DEPTH) || (m_drain && st_valid);
      for (int p = 0; p < PEERS; p++)
        if (ack_vld[p])
          foreach (q[i]) if (q[i].slot == int'(ack_slot[p*IW +: IW]) && q[i].acks < PEERS) q[i].acks++;
      if (pop) void'(q.pop_front());
      if (st_valid && !stall) begin
        q.push_back('{a: st_addr, d: st_data, acks: 0, slot: m_tail});
        m_tail = (m_tail + 1) % DEPTH;
      end
      m_drain = (m_drain || fence_req) && (q.size() != 0);
    end
  end

  // Compare every port against the model away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit stall_e, cw_e;
      stall_e = (q.size() == DEPTH) || (m_drain && st_valid);
      chk(cur_req, "st_stall", st_stall, stall_e);
      chk(cur_req, "inv_req_valid", inv_req_valid, st_valid && !stall_e);
      if (st_valid && !stall_e) begin
        chk(cur_req, "inv_req_slot (R1)", inv_req_slot, m_tail);
        chk(cur_req, "inv_req_addr (R1)", inv_req_addr, st_addr);
      end
      cw_e = (q.size() > 0) && (q[0].acks == PEERS);
      chk(cur_req, "cwr_valid", cwr_valid, cw_e);
      if (cw_e) begin
        chk(cur_req, "cwr_addr", cwr_addr, q[0].a);
        chk(cur_req, "cwr_data", cwr_data, q[0].d);
      end
      chk(cur_req, "ld_rsp_valid", ld_rsp_valid, e_rv);
      if (e_rv) begin
        chk(cur_req, "ld_rsp_hit", ld_rsp_hit, e_hit);
        chk(cur_req, "ld_rsp_data", ld_rsp_data, e_rd);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    st_valid = 0; fence_req = 0; ack_vld = '0; ld_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) tick();
  endtask

  task automatic store(logic [AW-1:0] a, logic [DW-1:0] d);
    st_valid = 1; st_addr = a; st_data = d; tick();
  endtask

  task automatic set_acks(int idx, logic [PEERS-1:0] mask);
    for (int p = 0; p < PEERS; p++)
      if (mask[p]) begin ack_vld[p] = 1; ack_slot[p*IW +: IW] = IW'(q[idx].slot); end
  endtask

  task automatic ack_slot_raw(int slot, logic [PEERS-1:0] mask);
    for (int p = 0; p < PEERS; p++)
      if (mask[p]) begin ack_vld[p] = 1; ack_slot[p*IW +: IW] = IW'(slot); end
    tick();
  endtask

  task automatic load(logic [AW-1:0] a);
    ld_valid = 1; ld_addr = a; tick();
  endtask

  task automatic drain_all();
    while (q.size() > 0) begin
      if (q[0].acks < PEERS) set_acks(0, '1);
      tick();
    end
  endtask

  initial begin
    done = 0;
    rst_n = 0; st_valid = 0; fence_req = 0; ld_valid = 0; ack_vld = '0;
    ack_slot = '0; st_addr = '0; st_data = '0; ld_addr = '0;
    repeat (3) @(negedge clk);
    cur_req = "R9";
    chk("R9", "st_stall in reset", st_stall, 0);
    chk("R9", "cwr_valid in reset", cwr_valid, 0);
    chk("R9", "inv_req_valid in reset", inv_req_valid, 0);
    chk("R9", "ld_rsp_valid in reset", ld_rsp_valid, 0);
    @(posedge clk); #1; rst_n = 1;
    idle(2);

    // R1 and R3: acknowledgements from peers arrive one per cycle.
    cur_req = "R1";
    store(16'h0100, 32'hA0A0_0001);
    cur_req = "R3";
    set_acks(0, 3'b001); tick();
    set_acks(0, 3'b100); tick();
    chk("R3", "no write before last ack", cwr_valid, 0);
    set_acks(0, 3'b010); tick();
    idle(3);

    // R10: all peers acknowledge one entry in one cycle.
    cur_req = "R10";
    store(16'h0200, 32'hB0B0_0002);
    set_acks(0, '1); tick();
    @(negedge clk);
    chk("R10", "write after simultaneous acks", cwr_valid, 1);
    idle(2);

    // R4: younger entry fully acknowledged first.
    cur_req = "R4";
    store(16'h0300, 32'h3333_0000);
    store(16'h0304, 32'h3333_0004);
    set_acks(1, '1); tick();
    idle(3);
    set_acks(0, '1); tick();
    idle(4);

    // R5: forwarding picks the youngest of several matches; miss returns zero.
    cur_req = "R5";
    store(16'h0400, 32'h5555_0001);
    store(16'h0480, 32'h5555_0080);
    store(16'h0400, 32'h5555_0002);
    load(16'h0400);
    load(16'h0480);
    load(16'h0999);
    store(16'h0400, 32'h5555_0003);
    ld_valid = 1; ld_addr = 16'h0400; tick();
    // Load in the same cycle as store: the new store is not yet visible.
    st_valid = 1; st_addr = 16'h0500; st_data = 32'h5555_0500;
    ld_valid = 1; ld_addr = 16'h0500; tick();
    // Load in the same cycle as the entry writes the cache.
    for (int k = 0; k < 6; k++) begin
      if (q.size() > 0 && q[0].acks < PEERS) set_acks(0, '1);
      if (q.size() > 0 && q[0].acks == PEERS) begin ld_valid = 1; ld_addr = q[0].a; end
      tick();
    end
    drain_all();
    idle(2);

    // R2: fill all slots, then a further store must stall.
    cur_req = "R2";
    for (int k = 0; k < DEPTH; k++) store(16'h0600 + AW'(k), 32'h6000_0000 + k);
    st_valid = 1; st_addr = 16'h06FF; st_data = 32'h6666_FFFF;
    @(negedge clk);
    chk("R2", "stall when full", st_stall, 1);
    tick();
    @(negedge clk);
    chk("R2", "stall when full, no store", st_stall, 1);
    drain_all();
    idle(2);

    // R6: fence with a concurrent store, then a held store waits for the drain.
    cur_req = "R6";
    store(16'h0700, 32'h7000_0000);
    store(16'h0704, 32'h7000_0004);
    fence_req = 1; st_valid = 1; st_addr = 16'h0708; st_data = 32'h7000_0008; tick();
    for (int k = 0; k < 14; k++) begin
      st_valid = 1; st_addr = 16'h070C; st_data = 32'h7000_000C;
      if (k % 3 == 2 && q.size() > 0 && q[0].acks < PEERS) set_acks(0, '1);
      if (k == 0) begin
        @(negedge clk);
        chk("R6", "stall during drain", st_stall, 1);
      end
      tick();
    end
    drain_all();
    idle(2);

    // R7: fence on an empty queue.
    cur_req = "R7";
    fence_req = 1; tick();
    st_valid = 1; st_addr = 16'h0800; st_data = 32'h8888_0000;
    @(negedge clk);
    chk("R7", "no stall after fence on empty queue", st_stall, 0);
    tick();
    drain_all();
    idle(2);

    // R8: a stray acknowledgement to an empty slot is not credited later.
    cur_req = "R8";
    ack_slot_raw(m_tail, '1);
    store(16'h0900, 32'h9999_0000);
    set_acks(0, 3'b011); tick();
    idle(2);
    @(negedge clk);
    chk("R8", "stray ack not credited", cwr_valid, 0);
    set_acks(0, 3'b100); tick();
    @(negedge clk);
    chk("R8", "write after fresh acks", cwr_valid, 1);
    idle(3);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired in %s actual=running expected=finished", cur_req);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule